// File: doc/BRIEF.md
# I2C Slave Bus Condition and Address Detector

This block watches the clock and data lines of a two-wire serial bus from the slave side. Both raw lines are first brought into the system clock domain and passed through a glitch filter. A line's new level is accepted only after it has held steady for a programmable number of system clocks. The filtered lines feed a condition detector that recognises the opening condition (data falling while the clock is high), the closing condition (data rising while the clock is high), and an opening condition that arrives while a transfer is already under way.

After every opening condition the block shifts in the first byte, sampling data on each rising clock edge with the most significant bit first. The upper seven bits are compared with a programmed own address. When broadcast matching is enabled, they are also compared with the all-zero broadcast address. Each kind of match has its own flag. The eighth bit is reported as the read/write direction. If a match occurred and acknowledging is enabled, the block asks for the data line to be pulled low for the whole ninth clock. A closing condition or a new opening condition discards a partly received byte and clears every flag.

The surrounding slave logic uses the event pulses and flags to decide whether to take part in the transfer. The system clock must run at least 16 times faster than the bus clock.

Top module: `i2c_addr_watch`

## Requirements
- R1: A level change on either raw line is accepted only after the raw line has held the new level for FILT_CYCLES consecutive clocks. A shorter pulse changes no output. An accepted change shows at the outputs FILT_CYCLES+3 clocks after the raw change.
- R2: After reset every output is 0, and both filtered lines are taken as high (idle bus).
- R3: When no transfer is active, filtered SDA falling while filtered SCL is high in that cycle and the previous one gives a one-cycle pulse on start_o, and address reception begins.
- R4: The same condition while a transfer is active gives a one-cycle pulse on rstart_o instead of start_o, and address reception begins again.
- R5: Filtered SDA rising while filtered SCL is high in that cycle and the previous one gives a one-cycle pulse on stop_o. It ends the transfer and clears own_hit_o, gen_hit_o, rw_o and sda_low_o.
- R6: SDA is sampled on each filtered SCL rising edge, most significant bit first. After the 8th sample, own_hit_o is 1 exactly when sampled bits 7..1 equal own_addr_i.
- R7: After the 8th sample, gen_hit_o is 1 exactly when sampled bits 7..1 are all zero and gc_en_i is 1. With gc_en_i at 0, the all-zero address sets no flag and gets no acknowledge.
- R8: After the 8th sample, rw_o equals sampled bit 0, where 1 means read.
- R9: sda_low_o rises on the first filtered SCL fall after the 8th sample, only if own_hit_o or gen_hit_o is set and ack_en_i is 1. It falls on the next filtered SCL fall, so it covers the 9th clock.
- R10: A START or repeated START discards any partly received byte and clears the flags. The next 8 SCL rising edges form a complete new address byte.
- R11: Once the address phase is over, further SCL clocks leave the flags unchanged until the next START, repeated START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_raw_i | input | 1 | Raw bus clock line |
| sda_raw_i | input | 1 | Raw bus data line |
| own_addr_i | input | 7 | Programmed own address |
| gc_en_i | input | 1 | Enables matching of the all-zero broadcast address |
| ack_en_i | input | 1 | Enables the acknowledge drive on a match |
| start_o | output | 1 | One-cycle pulse on START from idle |
| rstart_o | output | 1 | One-cycle pulse on repeated START |
| stop_o | output | 1 | One-cycle pulse on STOP |
| own_hit_o | output | 1 | Own address matched |
| gen_hit_o | output | 1 | Broadcast address matched |
| rw_o | output | 1 | Direction bit of the address byte (1 = read) |
| sda_low_o | output | 1 | Request to pull SDA low (acknowledge) |

## Verification
A raw edge reaches the filtered level after FILT_CYCLES+2 clocks: two synchroniser stages, then the stability count. The registered pulses, flags and acknowledge request follow one clock later, so each result is due FILT_CYCLES+3 clocks after the stimulus that causes it. The bench reference model advances with the same per-clock timing and is compared with every output on every falling clock edge, so an early or late result counts as a miscompare. The directed checks sample in the middle of bus phases that last 12 clocks, well after every result is due and before the next stimulus.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ACK_WAIT,
        PH_ACK_DRIVE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [BIT_W-1:0]    bits;
        logic [BYTE_W-1:0]   shreg;
        logic                own_hit;
        logic                gen_hit;
        logic                rw;
        logic                sda_low;
        logic                start_p;
        logic                rstart_p;
        logic                stop_p;
    } engine_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int CNT_W = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LIM = CNT_W'(FILT_CYCLES - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } filt_t;

    filt_t d, q;

    always_comb begin
        d    = q;
        d.s1 = raw_i;
        d.s2 = q.s1;
        if (q.s2 == q.lvl) begin
            d.cnt = '0;
        end else if (q.cnt == LIM) begin
            d.lvl = q.s2;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{s1: 1'b1, s2: 1'b1, lvl: 1'b1, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign lvl_o = q.lvl;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_watch_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_c_o,
    output logic stop_c_o,
    output logic rise_o,
    output logic fall_o
);
    prev_t d, q;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    // SCL high across both cycles qualifies a data edge as a bus condition
    assign start_c_o = scl_i & q.scl & q.sda & ~sda_i;
    assign stop_c_o  = scl_i & q.scl & ~q.sda & sda_i;
    assign rise_o    = scl_i & ~q.scl;
    assign fall_o    = ~scl_i & q.scl;

endmodule

// File: rtl/i2c_addr_engine.sv
module i2c_addr_engine
    import i2c_watch_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sda_i,
    input  logic              start_c_i,
    input  logic              stop_c_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    input  logic              ack_en_i,
    output logic              start_o,
    output logic              rstart_o,
    output logic              stop_o,
    output logic              own_hit_o,
    output logic              gen_hit_o,
    output logic              rw_o,
    output logic              sda_low_o
);
    engine_t d, q;
    logic [BYTE_W-1:0] byte_nx;

    always_comb begin
        d          = q;
        d.start_p  = 1'b0;
        d.rstart_p = 1'b0;
        d.stop_p   = 1'b0;
        byte_nx    = {q.shreg[BYTE_W-2:0], sda_i};

        if (start_c_i) begin
            if (q.phase != PH_IDLE) begin
                d.rstart_p = 1'b1;
            end else begin
                d.start_p = 1'b1;
            end
            d.phase   = PH_ADDR;
            d.bits    = '0;
            d.shreg   = '0;
            d.own_hit = 1'b0;
            d.gen_hit = 1'b0;
            d.rw      = 1'b0;
            d.sda_low = 1'b0;
        end else if (stop_c_i) begin
            d.stop_p  = 1'b1;
            d.phase   = PH_IDLE;
            d.bits    = '0;
            d.shreg   = '0;
            d.own_hit = 1'b0;
            d.gen_hit = 1'b0;
            d.rw      = 1'b0;
            d.sda_low = 1'b0;
        end else begin
            unique case (q.phase)
                PH_ADDR: begin
                    if (rise_i) begin
                        d.shreg = byte_nx;
                        d.bits  = q.bits + 1'b1;
                        if (q.bits == BIT_LAST) begin
                            d.own_hit = (byte_nx[BYTE_W-1:1] == own_addr_i);
                            d.gen_hit = gc_en_i && (byte_nx[BYTE_W-1:1] == '0);
                            d.rw      = byte_nx[0];
                            d.phase   = PH_ACK_WAIT;
                        end
                    end
                end
                PH_ACK_WAIT: begin
                    if (fall_i) begin
                        d.sda_low = (q.own_hit | q.gen_hit) & ack_en_i;
                        d.phase   = PH_ACK_DRIVE;
                    end
                end
                PH_ACK_DRIVE: begin
                    if (fall_i) begin
                        d.sda_low = 1'b0;
                        d.phase   = PH_HOLD;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{phase: PH_IDLE, bits: '0, shreg: '0, own_hit: 1'b0,
                   gen_hit: 1'b0, rw: 1'b0, sda_low: 1'b0, start_p: 1'b0,
                   rstart_p: 1'b0, stop_p: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign start_o   = q.start_p;
    assign rstart_o  = q.rstart_p;
    assign stop_o    = q.stop_p;
    assign own_hit_o = q.own_hit;
    assign gen_hit_o = q.gen_hit;
    assign rw_o      = q.rw;
    assign sda_low_o = q.sda_low;

endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
    import i2c_watch_pkg::*;
#(
    parameter int FILT_CYCLES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_raw_i,
    input  logic              sda_raw_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    input  logic              ack_en_i,
    output logic              start_o,
    output logic              rstart_o,
    output logic              stop_o,
    output logic              own_hit_o,
    output logic              gen_hit_o,
    output logic              rw_o,
    output logic              sda_low_o
);
    localparam int N_LINES = 2;
    localparam int L_SCL   = 0;
    localparam int L_SDA   = 1;

    logic [N_LINES-1:0] raw_v;
    logic [N_LINES-1:0] lvl_v;
    logic start_c, stop_c, rise_c, fall_c;

    assign raw_v[L_SCL] = scl_raw_i;
    assign raw_v[L_SDA] = sda_raw_i;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(
            .FILT_CYCLES(FILT_CYCLES)
        ) u_filt (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .raw_i (raw_v[g]),
            .lvl_o (lvl_v[g])
        );
    end

    i2c_bus_events u_events (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .scl_i    (lvl_v[L_SCL]),
        .sda_i    (lvl_v[L_SDA]),
        .start_c_o(start_c),
        .stop_c_o (stop_c),
        .rise_o   (rise_c),
        .fall_o   (fall_c)
    );

    i2c_addr_engine u_engine (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sda_i     (lvl_v[L_SDA]),
        .start_c_i (start_c),
        .stop_c_i  (stop_c),
        .rise_i    (rise_c),
        .fall_i    (fall_c),
        .own_addr_i(own_addr_i),
        .gc_en_i   (gc_en_i),
        .ack_en_i  (ack_en_i),
        .start_o   (start_o),
        .rstart_o  (rstart_o),
        .stop_o    (stop_o),
        .own_hit_o (own_hit_o),
        .gen_hit_o (gen_hit_o),
        .rw_o      (rw_o),
        .sda_low_o (sda_low_o)
    );

endmodule

// File: rtl/i2c_addr_watch_chk.sv
module i2c_addr_watch_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic gc_en_i,
    input logic ack_en_i,
    input logic start_o,
    input logic rstart_o,
    input logic stop_o,
    input logic own_hit_o,
    input logic gen_hit_o,
    input logic rw_o,
    input logic sda_low_o
);
    // R3 R4 R5: at most one bus event per cycle
    a_r3_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({start_o, rstart_o, stop_o}));

    a_r9_ack_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_low_o) |-> ($past(ack_en_i) && (own_hit_o || gen_hit_o)));

    a_r7_gen_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gen_hit_o) |-> $past(gc_en_i));

    a_r5_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_o |-> (!own_hit_o && !gen_hit_o && !rw_o && !sda_low_o));

    a_r10_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o || rstart_o) |-> (!own_hit_o && !gen_hit_o && !sda_low_o));

    a_r11_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(own_hit_o) && !start_o && !rstart_o && !stop_o) |-> own_hit_o);

endmodule

bind i2c_addr_watch i2c_addr_watch_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gc_en_i  (gc_en_i),
    .ack_en_i (ack_en_i),
    .start_o  (start_o),
    .rstart_o (rstart_o),
    .stop_o   (stop_o),
    .own_hit_o(own_hit_o),
    .gen_hit_o(gen_hit_o),
    .rw_o     (rw_o),
    .sda_low_o(sda_low_o)
);

// File: tb/test_i2c_addr_watch.sv
module test_i2c_addr_watch;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 4;
    localparam int H          = 12;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_r = 1'b1;
    logic sda_r = 1'b1;
    logic [6:0] own = OWN;
    logic gc_en = 1'b0;
    logic ack_en = 1'b1;
    logic start_w, rstart_w, stop_w, own_w, gen_w, rw_w, low_w;

    int vectors = 0;
    int miscompares = 0;
    int n_start = 0, n_rstart = 0, n_stop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_watch #(.FILT_CYCLES(FILT)) i_i2c_addr_watch (
        .clk_i(clk), .rst_ni(rst_n), .scl_raw_i(scl_r), .sda_raw_i(sda_r),
        .own_addr_i(own), .gc_en_i(gc_en), .ack_en_i(ack_en),
        .start_o(start_w), .rstart_o(rstart_w), .stop_o(stop_w),
        .own_hit_o(own_w), .gen_hit_o(gen_w), .rw_o(rw_w), .sda_low_o(low_w)
    );

    // ---------------- reference model ----------------
    bit q_scl[$];
    bit q_sda[$];
    int cnt_scl, cnt_sda;
    bit f_scl, f_sda, p_scl, p_sda;
    int m_state;   // 0 idle, 1 address, 2 wait ack, 3 ack, 4 hold
    int m_nbits;
    bit [7:0] m_byte;
    bit e_start, e_rstart, e_stop, e_own, e_gen, e_rw, e_low;

    task automatic model_reset();
        q_scl = {1'b1, 1'b1};
        q_sda = {1'b1, 1'b1};
        cnt_scl = 0; cnt_sda = 0;
        f_scl = 1; f_sda = 1; p_scl = 1; p_sda = 1;
        m_state = 0; m_nbits = 0; m_byte = 0;
        e_start = 0; e_rstart = 0; e_stop = 0;
        e_own = 0; e_gen = 0; e_rw = 0; e_low = 0;
    endtask

    task automatic clear_flags();
        m_nbits = 0; m_byte = 0;
        e_own = 0; e_gen = 0; e_rw = 0; e_low = 0;
    endtask

    task automatic model_step();
        bit rise, fall, cstart, cstop, old;
        rise   = f_scl && !p_scl;
        fall   = !f_scl && p_scl;
        cstart = f_scl && p_scl && p_sda && !f_sda;
        cstop  = f_scl && p_scl && !p_sda && f_sda;
        e_start = 0; e_rstart = 0; e_stop = 0;
        if (cstart) begin
            if (m_state != 0) e_rstart = 1; else e_start = 1;
            m_state = 1;
            clear_flags();
        end else if (cstop) begin
            e_stop = 1;
            m_state = 0;
            clear_flags();
        end else if (m_state == 1 && rise) begin
            m_byte = {m_byte[6:0], f_sda};
            m_nbits++;
            if (m_nbits == 8) begin
                e_own = (m_byte[7:1] == own);
                e_gen = gc_en && (m_byte[7:1] == 7'd0);
                e_rw  = m_byte[0];
                m_state = 2;
            end
        end else if (m_state == 2 && fall) begin
            e_low = (e_own || e_gen) && ack_en;
            m_state = 3;
        end else if (m_state == 3 && fall) begin
            e_low = 0;
            m_state = 4;
        end
        p_scl = f_scl;
        p_sda = f_sda;
        // glitch filter: change accepted after FILT consecutive differing samples
        old = q_scl[0];
        if (old == f_scl) cnt_scl = 0;
        else if (cnt_scl == FILT-1) begin f_scl = old; cnt_scl = 0; end
        else cnt_scl++;
        void'(q_scl.pop_front());
        q_scl.push_back(scl_r);
        old = q_sda[0];
        if (old == f_sda) cnt_sda = 0;
        else if (cnt_sda == FILT-1) begin f_sda = old; cnt_sda = 0; end
        else cnt_sda++;
        void'(q_sda.pop_front());
        q_sda.push_back(sda_r);
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    function automatic bit differs(string tag, logic act, bit exp);
        if (act !== exp) begin
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
            return 1;
        end
        return 0;
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit bad;
            bad = 0;
            bad |= differs("R3 start_o", start_w, e_start);
            bad |= differs("R4 rstart_o", rstart_w, e_rstart);
            bad |= differs("R5 stop_o", stop_w, e_stop);
            bad |= differs("R6 own_hit_o", own_w, e_own);
            bad |= differs("R7 gen_hit_o", gen_w, e_gen);
            bad |= differs("R8 rw_o", rw_w, e_rw);
            bad |= differs("R9 sda_low_o", low_w, e_low);
            vectors++;
            if (bad) miscompares++;
            if (start_w === 1'b1) n_start++;
            if (rstart_w === 1'b1) n_rstart++;
            if (stop_w === 1'b1) n_stop++;
        end
    end

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- bus stimulus ----------------
    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_r = 1; wait_n(H);
        scl_r = 1; wait_n(H);
        sda_r = 0; wait_n(H);
        scl_r = 0; wait_n(H);
    endtask

    task automatic bus_stop();
        sda_r = 0; wait_n(H);
        scl_r = 1; wait_n(H);
        sda_r = 1; wait_n(H);
    endtask

    task automatic send_bit(bit b);
        sda_r = b; wait_n(H);
        scl_r = 1; wait_n(H);
        scl_r = 0; wait_n(H);
    endtask

    task automatic send_byte(bit [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    // 9th clock: master releases SDA, the acknowledge is checked mid-high
    task automatic ack_slot(bit exp_low, string req);
        sda_r = 1; wait_n(H);
        scl_r = 1; wait_n(H/2);
        chk(req, int'(low_w), int'(exp_low));
        wait_n(H - H/2);
        scl_r = 0; wait_n(H);
    endtask

    task automatic flags(bit eo, bit eg, bit er, string req);
        chk({req, " own_hit_o"}, int'(own_w), int'(eo));
        chk({req, " gen_hit_o"}, int'(gen_w), int'(eg));
        chk({req, " rw_o"}, int'(rw_w), int'(er));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        int s0, p0;
        wait_n(5);
        rst_n = 1;
        wait_n(3);
        // R2 reset state
        chk("R2 outputs after reset", int'({start_w, rstart_w, stop_w, own_w, gen_w, rw_w, low_w}), 0);

        // R3 R6 R9: own address write, acknowledge on
        bus_start();
        chk("R3 start count", n_start, 1);
        send_byte({OWN, 1'b0});
        ack_slot(1, "R9 ack driven on own match");
        flags(1, 0, 0, "R6 own write");

        // R4 R8 R9 R11: repeated start, read, acknowledge off
        ack_en = 0;
        bus_start();
        chk("R4 repeated start count", n_rstart, 1);
        chk("R4 no plain start", n_start, 1);
        send_byte({OWN, 1'b1});
        ack_slot(0, "R9 no ack when disabled");
        flags(1, 0, 1, "R8 own read");
        send_bit(0);
        send_bit(1);
        flags(1, 0, 1, "R11 flags held over extra clocks");

        // R5 stop clears
        bus_stop();
        chk("R5 stop count", n_stop, 1);
        flags(0, 0, 0, "R5 after stop");

        // R7 broadcast enabled
        ack_en = 1; gc_en = 1;
        bus_start();
        send_byte(8'h00);
        ack_slot(1, "R9 ack on broadcast");
        flags(0, 1, 0, "R7 broadcast enabled");
        bus_stop();

        // R7 broadcast disabled
        gc_en = 0;
        bus_start();
        send_byte(8'h00);
        ack_slot(0, "R7 no ack broadcast disabled");
        flags(0, 0, 0, "R7 broadcast disabled");
        bus_stop();

        // R6 mismatch
        bus_start();
        send_byte({OWN ^ 7'h01, 1'b0});
        ack_slot(0, "R6 no ack on mismatch");
        flags(0, 0, 0, "R6 mismatch");
        bus_stop();

        // R5 R10: stop aborts a partial byte
        bus_start();
        send_bit(1); send_bit(0); send_bit(1);
        bus_stop();
        flags(0, 0, 0, "R5 abort partial");
        bus_start();
        send_byte({OWN, 1'b0});
        ack_slot(1, "R10 full byte after abort");
        flags(1, 0, 0, "R10 fresh byte after stop");

        // R10: repeated start in the middle of the address byte
        bus_start();
        send_bit(0); send_bit(1); send_bit(1); send_bit(0);
        bus_start();
        flags(0, 0, 0, "R10 cleared by repeated start");
        send_byte({OWN, 1'b1});
        ack_slot(1, "R10 ack after restart");
        flags(1, 0, 1, "R10 fresh byte after restart");
        bus_stop();

        // R1: short SDA pulses on an idle bus are ignored
        s0 = n_start; p0 = n_stop;
        sda_r = 0; wait_n(2); sda_r = 1; wait_n(H);
        sda_r = 0; wait_n(FILT-1); sda_r = 1; wait_n(H);
        chk("R1 glitch start ignored", n_start, s0);
        chk("R1 glitch stop ignored", n_stop, p0);
        // R1: a pulse of exactly FILT clocks is accepted
        sda_r = 0; wait_n(FILT); sda_r = 1; wait_n(H);
        chk("R1 accepted pulse start", n_start, s0 + 1);
        chk("R1 accepted pulse stop", n_stop, p0 + 1);

        // R1: SCL spike inside a bit's low phase adds no sample
        bus_start();
        send_bit(OWN[6]); send_bit(OWN[5]); send_bit(OWN[4]);
        sda_r = OWN[3]; wait_n(H/2);
        scl_r = 1; wait_n(FILT-1); scl_r = 0; wait_n(H);
        scl_r = 1; wait_n(H); scl_r = 0; wait_n(H);
        send_bit(OWN[2]); send_bit(OWN[1]); send_bit(OWN[0]); send_bit(0);
        ack_slot(1, "R1 SCL spike filtered");
        flags(1, 0, 0, "R1 SCL spike filtered");
        bus_stop();

        wait_n(H);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
        $finish;
    end

endmodule